// File: doc/BRIEF.md
# Context-Based Register Bank Addressing

This block maps the sixteen word-wide general registers of a processor onto a data RAM instead of a flip-flop register file. A base register, called the context pointer here, holds the byte address at which the active bank begins. Every register number used by the execution stage is turned into a RAM address from that base. Moving the pointer switches to another bank without copying any data. Two pointer values that lie less than 32 bytes apart give banks that overlap, so a caller and a callee can share words for passing parameters.

The block holds the pointer register and a 1024-word by 16-bit synchronous RAM, which is the 2K-byte internal RAM. It has two register read ports, one register write port, and one plain word port into the same RAM. Through the word port the rest of the chip sees the register contents as ordinary memory. All reads are synchronous: an index or address presented in one cycle returns its data after the next rising edge. The three register-port byte addresses are also driven out, so that the execution stage can use them for address-type operands and trace.

Top module: `ctxBankRegs`

## Requirements
- R1: While rstN is low, cpValue, rdAData, rdBData and memRData are all zero.
- R2: When cpWrEn is high at a rising edge, cpValue becomes cpWrData with bit 0 cleared. When cpWrEn is low, cpValue keeps its value.
- R3: rdAAddr, rdBAddr and wrAddr each equal cpValue plus twice the matching register index, truncated to ADDR_W bits. They are combinational in the current pointer and index.
- R4: Every register access made in the same cycle as a pointer write uses the old pointer. The new pointer applies from the next cycle on.
- R5: Each read port (rdAData, rdBData, memRData) shows, one cycle after the address is presented, the RAM word at that address.
- R6: A register write with wrEn high stores wrData into the RAM word at wrAddr on the rising edge.
- R7: Banks overlap. Register Rn under pointer P and register Rm under pointer Q address the same RAM word when P + 2n equals Q + 2m.
- R8: A register write can be read back through the word port, and a word-port write (memWe high) can be read back through a register port.
- R9: A read whose address matches a write in the same cycle returns the data being written, not the old word.
- R10: When the register write and the word-port write hit the same word in one cycle, the register write wins. This holds both for the stored word and for data forwarded to reads.
- R11: Register addresses wrap modulo the RAM size (2^ADDR_W bytes). A bank that starts near the top of the RAM continues at address 0.
- R12: Bit 0 of memAddr has no effect. The word port always reaches the whole 16-bit word that holds the given byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpWrEn | input | 1 | Load the context pointer |
| cpWrData | input | ADDR_W (11) | New context pointer byte address |
| cpValue | output | ADDR_W (11) | Current context pointer |
| rdAIdx | input | IDX_W (4) | Register number for read port A |
| rdAAddr | output | ADDR_W (11) | Byte address of read port A register |
| rdAData | output | DATA_W (16) | Read port A data, one cycle after the index |
| rdBIdx | input | IDX_W (4) | Register number for read port B |
| rdBAddr | output | ADDR_W (11) | Byte address of read port B register |
| rdBData | output | DATA_W (16) | Read port B data, one cycle after the index |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | IDX_W (4) | Register number to write |
| wrAddr | output | ADDR_W (11) | Byte address of the register being written |
| wrData | input | DATA_W (16) | Register write data |
| memAddr | input | ADDR_W (11) | Byte address for the plain word port |
| memWe | input | 1 | Word port write enable |
| memWData | input | DATA_W (16) | Word port write data |
| memRData | output | DATA_W (16) | Word port read data, one cycle after the address |

## Verification
The forwarding assertions take for granted that wrData and memWData are steady through the cycle of a write, so the value seen one edge later equals the value sampled by $past. The stimulus changes every input only on the falling edge. The stride assertion needs ADDR_W to be larger than IDX_W. The bench keeps the default widths and drives only 4-bit indices and 11-bit addresses. Near the top of the RAM the bench chooses pointers on purpose, so that the wrap exercises the modular arithmetic that the assertion relies on.

// File: rtl/ctxBankPkg.sv
package ctxBankPkg;

  // Source of a read port's next value
  typedef enum logic [1:0] {
    FWD_NONE = 2'd0,
    FWD_REG  = 2'd1,
    FWD_MEM  = 2'd2
  } fwdSel_e;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic    regWe;
    logic    memWe;
    fwdSel_e fwdA;
    fwdSel_e fwdB;
    fwdSel_e fwdM;
  } bankStrobes_t;

endpackage

// File: rtl/ctxBankCtrl.sv
module ctxBankCtrl
  import ctxBankPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpWrEn,
  input  logic [ADDR_W-1:0] cpWrData,
  input  logic [IDX_W-1:0]  rdAIdx,
  input  logic [IDX_W-1:0]  rdBIdx,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] cpValue,
  output logic [ADDR_W-1:0] rdAAddr,
  output logic [ADDR_W-1:0] rdBAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-2:0] rdAWord,
  output logic [ADDR_W-2:0] rdBWord,
  output logic [ADDR_W-2:0] wrWord,
  output logic [ADDR_W-2:0] memWord,
  output bankStrobes_t      strobes
);

  localparam int WORD_W = ADDR_W - 1;
  localparam int NUM_RD = 3;  // port A, port B, word port

  logic [ADDR_W-1:0] cpQ;
  logic              unusedMemLsb;

  // Context pointer: word aligned, new value visible from the next cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpQ <= '0;
    end else if (cpWrEn) begin
      cpQ <= cpWrData & ~ADDR_W'(1);
    end
  end

  assign cpValue = cpQ;

  function automatic logic [ADDR_W-1:0] regAddr(
    input logic [ADDR_W-1:0] base,
    input logic [IDX_W-1:0]  idx
  );
    return base + (ADDR_W'(idx) << 1);
  endfunction

  assign rdAAddr = regAddr(cpQ, rdAIdx);
  assign rdBAddr = regAddr(cpQ, rdBIdx);
  assign wrAddr  = regAddr(cpQ, wrIdx);

  assign rdAWord = rdAAddr[ADDR_W-1:1];
  assign rdBWord = rdBAddr[ADDR_W-1:1];
  assign wrWord  = wrAddr[ADDR_W-1:1];
  assign memWord = memAddr[ADDR_W-1:1];
  assign unusedMemLsb = memAddr[0];

  // Forwarding selection for each read port; the register write wins
  logic [WORD_W-1:0] rdWords [NUM_RD];
  fwdSel_e           fwdSel  [NUM_RD];

  assign rdWords[0] = rdAWord;
  assign rdWords[1] = rdBWord;
  assign rdWords[2] = memWord;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_fwd
    always_comb begin
      if (wrEn && (rdWords[p] == wrWord)) begin
        fwdSel[p] = FWD_REG;
      end else if (memWe && (rdWords[p] == memWord)) begin
        fwdSel[p] = FWD_MEM;
      end else begin
        fwdSel[p] = FWD_NONE;
      end
    end
  end

  always_comb begin
    strobes.regWe = wrEn;
    strobes.memWe = memWe;
    strobes.fwdA  = fwdSel[0];
    strobes.fwdB  = fwdSel[1];
    strobes.fwdM  = fwdSel[2];
  end

  // R2: pointer load clears bit 0
  a_r2_cp_load: assert property (@(posedge clk) disable iff (!rstN)
    cpWrEn |=> (cpValue == ($past(cpWrData) & ~ADDR_W'(1))));

  // R2 / R4: pointer holds without a load
  a_r4_cp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cpWrEn |=> $stable(cpValue));

  // R3 / R11: two register addresses differ by twice the index difference, modulo RAM size
  a_r3_addr_stride: assert property (@(posedge clk) disable iff (!rstN)
    (ADDR_W'(rdAAddr - rdBAddr)) == ((ADDR_W'(rdAIdx) - ADDR_W'(rdBIdx)) << 1));

endmodule

// File: rtl/ctxBankData.sv
module ctxBankData
  import ctxBankPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strobes,
  input  logic [ADDR_W-2:0] rdAWord,
  input  logic [ADDR_W-2:0] rdBWord,
  input  logic [ADDR_W-2:0] wrWord,
  input  logic [ADDR_W-2:0] memWord,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memWData,
  output logic [DATA_W-1:0] rdAData,
  output logic [DATA_W-1:0] rdBData,
  output logic [DATA_W-1:0] memRData
);

  localparam int WORD_W = ADDR_W - 1;
  localparam int DEPTH  = 1 << WORD_W;

  logic [DATA_W-1:0] ram [DEPTH];
  logic [DATA_W-1:0] nextA, nextB, nextM;
  logic [DATA_W-1:0] rdAQ, rdBQ, memQ;

  // Word port first, register write last so it wins on a shared word
  always_ff @(posedge clk) begin
    if (strobes.memWe) begin
      ram[memWord] <= memWData;
    end
    if (strobes.regWe) begin
      ram[wrWord] <= wrData;
    end
  end

  function automatic logic [DATA_W-1:0] pickData(
    input fwdSel_e           sel,
    input logic [DATA_W-1:0] stored
  );
    case (sel)
      FWD_REG: return wrData;
      FWD_MEM: return memWData;
      default: return stored;
    endcase
  endfunction

  always_comb begin
    nextA = pickData(strobes.fwdA, ram[rdAWord]);
    nextB = pickData(strobes.fwdB, ram[rdBWord]);
    nextM = pickData(strobes.fwdM, ram[memWord]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAQ <= '0;
      rdBQ <= '0;
      memQ <= '0;
    end else begin
      rdAQ <= nextA;
      rdBQ <= nextB;
      memQ <= nextM;
    end
  end

  assign rdAData  = rdAQ;
  assign rdBData  = rdBQ;
  assign memRData = memQ;

  // R9 / R10: register-write forwarding to port A
  a_r9_fwd_reg_a: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fwdA == FWD_REG) |=> (rdAData == $past(wrData)));

  // R9: word-port-write forwarding to port B
  a_r9_fwd_mem_b: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fwdB == FWD_MEM) |=> (rdBData == $past(memWData)));

  // R10: colliding writes forward the register data to the word port
  a_r10_reg_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.regWe && strobes.memWe && (wrWord == memWord))
      |=> (memRData == $past(wrData)));

endmodule

// File: rtl/ctxBankRegs.sv
module ctxBankRegs
  import ctxBankPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpWrEn,
  input  logic [ADDR_W-1:0] cpWrData,
  output logic [ADDR_W-1:0] cpValue,
  input  logic [IDX_W-1:0]  rdAIdx,
  output logic [ADDR_W-1:0] rdAAddr,
  output logic [DATA_W-1:0] rdAData,
  input  logic [IDX_W-1:0]  rdBIdx,
  output logic [ADDR_W-1:0] rdBAddr,
  output logic [DATA_W-1:0] rdBData,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  output logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memWe,
  input  logic [DATA_W-1:0] memWData,
  output logic [DATA_W-1:0] memRData
);

  localparam int WORD_W = ADDR_W - 1;

  bankStrobes_t      strobes;
  logic [WORD_W-1:0] rdAWord, rdBWord, wrWord, memWord;

  ctxBankCtrl #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpWrEn   (cpWrEn),
    .cpWrData (cpWrData),
    .rdAIdx   (rdAIdx),
    .rdBIdx   (rdBIdx),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .cpValue  (cpValue),
    .rdAAddr  (rdAAddr),
    .rdBAddr  (rdBAddr),
    .wrAddr   (wrAddr),
    .rdAWord  (rdAWord),
    .rdBWord  (rdBWord),
    .wrWord   (wrWord),
    .memWord  (memWord),
    .strobes  (strobes)
  );

  ctxBankData #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdAWord  (rdAWord),
    .rdBWord  (rdBWord),
    .wrWord   (wrWord),
    .memWord  (memWord),
    .wrData   (wrData),
    .memWData (memWData),
    .rdAData  (rdAData),
    .rdBData  (rdBData),
    .memRData (memRData)
  );

endmodule

// File: tb/test_ctxBankRegs.sv
`timescale 1ns / 1ps
module test_ctxBankRegs;

  localparam int ADDR_W = 11;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cpWrEn;
  logic [ADDR_W-1:0] cpWrData;
  logic [ADDR_W-1:0] cpValue;
  logic [IDX_W-1:0]  rdAIdx, rdBIdx, wrIdx;
  logic [ADDR_W-1:0] rdAAddr, rdBAddr, wrAddr, memAddr;
  logic [DATA_W-1:0] rdAData, rdBData, wrData, memWData, memRData;
  logic              wrEn, memWe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ctxBankRegs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) i_ctxBankRegs (
    .clk      (clk),
    .rstN     (rstN),
    .cpWrEn   (cpWrEn),
    .cpWrData (cpWrData),
    .cpValue  (cpValue),
    .rdAIdx   (rdAIdx),
    .rdAAddr  (rdAAddr),
    .rdAData  (rdAData),
    .rdBIdx   (rdBIdx),
    .rdBAddr  (rdBAddr),
    .rdBData  (rdBData),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWData (memWData),
    .memRData (memRData)
  );

  // Vector: {pointer as written, register index, data}
  localparam int NVEC = 6;
  localparam logic [30:0] VECS [NVEC] = '{
    {11'h000, 4'd0,  16'h1111},
    {11'h100, 4'd3,  16'h2222},
    {11'h233, 4'd7,  16'h3333},
    {11'h7FA, 4'd5,  16'h4444},
    {11'h7FE, 4'd15, 16'h5555},
    {11'h400, 4'd9,  16'h6666}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full clock: rising edge, then back to the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    cpWrEn = 1'b0;
    wrEn   = 1'b0;
    memWe  = 1'b0;
  endtask

  task automatic loadCp(input logic [ADDR_W-1:0] v);
    cpWrEn   = 1'b1;
    cpWrData = v;
    tick();
    cpWrEn = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 1'b0;
    quiet();
    cpWrData = '0;
    rdAIdx = 4'd5; rdBIdx = '0; wrIdx = '0;
    wrData = '0; memWData = '0; memAddr = '0;
    @(negedge clk);
    repeat (3) tick();
    // R1 reset state
    chk("R1 cpValue", 32'(cpValue), 32'h0);
    chk("R1 rdAData", 32'(rdAData), 32'h0);
    chk("R1 rdBData", 32'(rdBData), 32'h0);
    chk("R1 memRData", 32'(memRData), 32'h0);
    #1 chk("R3 reset address", 32'(rdAAddr), 32'h00A);
    rstN = 1'b1;
    tick();

    // Vector table: load pointer, write a register, read it back two ways
    for (int i = 0; i < NVEC; i++) begin
      logic [ADDR_W-1:0] cpExp, addrExp;
      logic [IDX_W-1:0]  idx;
      logic [DATA_W-1:0] val;
      idx     = VECS[i][19:16];
      val     = VECS[i][15:0];
      cpExp   = VECS[i][30:20] & ~ADDR_W'(1);
      addrExp = cpExp + (ADDR_W'(idx) << 1);  // R11 wraps by truncation
      loadCp(VECS[i][30:20]);
      chk("R2 pointer load", 32'(cpValue), 32'(cpExp));
      wrEn = 1'b1; wrIdx = idx; wrData = val;
      #1 chk("R3/R11 write address", 32'(wrAddr), 32'(addrExp));
      tick();
      wrEn = 1'b0;
      rdAIdx = idx;
      memAddr = addrExp;
      #1 chk("R3 read address", 32'(rdAAddr), 32'(addrExp));
      tick();
      chk("R5/R6 register read", 32'(rdAData), 32'(val));
      chk("R8/R11 word port read", 32'(memRData), 32'(val));
    end

    // R4: pointer load and register write in one cycle; write uses old pointer
    rdAIdx = 4'd2;
    cpWrEn = 1'b1; cpWrData = 11'h300;
    wrEn = 1'b1; wrIdx = 4'd2; wrData = 16'hAAAA;
    #1 chk("R4 old pointer address", 32'(rdAAddr), 32'h404);
    tick();
    quiet();
    memAddr = 11'h404;
    #1 chk("R4 new pointer address", 32'(rdAAddr), 32'h304);
    tick();
    chk("R4 write landed at old base", 32'(memRData), 32'hAAAA);

    // R7: overlapping banks share words
    wrEn = 1'b1; wrIdx = 4'd8; wrData = 16'hBEEF;
    tick();
    wrEn = 1'b0;
    loadCp(11'h310);
    rdBIdx = 4'd0;
    #1 chk("R7 overlap address", 32'(rdBAddr), 32'h310);
    tick();
    chk("R7 overlap data", 32'(rdBData), 32'hBEEF);

    // R8: word port write read through a register port
    memWe = 1'b1; memAddr = 11'h312; memWData = 16'hCAFE;
    tick();
    memWe = 1'b0;
    rdAIdx = 4'd1;
    tick();
    chk("R8 word write seen by register", 32'(rdAData), 32'hCAFE);

    // R12: odd byte address reaches the whole word
    memWe = 1'b1; memAddr = 11'h315; memWData = 16'h1234;
    tick();
    memWe = 1'b0;
    rdAIdx = 4'd2;
    tick();
    chk("R12 odd address ignored bit", 32'(rdAData), 32'h1234);

    // R9: register write forwarded to all three read ports
    wrEn = 1'b1; wrIdx = 4'd3; wrData = 16'h5A5A;
    rdAIdx = 4'd3; rdBIdx = 4'd3; memAddr = 11'h316;
    tick();
    wrEn = 1'b0;
    chk("R9 forward port A", 32'(rdAData), 32'h5A5A);
    chk("R9 forward port B", 32'(rdBData), 32'h5A5A);
    chk("R9 forward word port", 32'(memRData), 32'h5A5A);

    // R9: word port write forwarded to a register read
    memWe = 1'b1; memAddr = 11'h318; memWData = 16'h7777;
    rdBIdx = 4'd4;
    tick();
    memWe = 1'b0;
    chk("R9 forward word write to port B", 32'(rdBData), 32'h7777);

    // R10: colliding writes, register write wins
    wrEn = 1'b1; wrIdx = 4'd5; wrData = 16'h1111;
    memWe = 1'b1; memAddr = 11'h31A; memWData = 16'h2222;
    rdAIdx = 4'd5;
    tick();
    quiet();
    chk("R10 forwarded winner", 32'(rdAData), 32'h1111);
    tick();
    chk("R10 stored winner", 32'(memRData), 32'h1111);

    summary();
  end

endmodule